// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is a register-programmed master for the two-wire management bus that configures external Ethernet PHYs. Software places a 16-bit value in a write-data register, selects the framing flavour (the older five-bit register addressing or the extended device/register addressing) with a mode bit in a configuration register, and launches a frame by writing a command register that holds an opcode, a PHY address and a register or device address. The block divides the system clock down to the management clock (MDC), serialises the frame MSB first on a tri-stateable data line (given as separate out, out-enable and in signals), and, for reads, releases the line at the turnaround, checks the PHY's turnaround response and shifts in 16 data bits.

Completion is reported through pending flags in the write-data and read-data registers, which software polls. A read result carries a valid flag that is set only when the PHY answered the turnaround correctly. An extended-mode access uses two frames: an address frame, whose 16-bit register number comes from the write-data register, then the write or read frame itself. Software waits for the first to finish before issuing the second. A command written while a frame is in flight, or carrying an opcode the current mode does not define, is dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, both pending flags (bit 31 of registers 2 and 3) and the valid flag (bit 30 of register 3) read 0, and MDC and the data out-enable are low.
- R2: Register 0 holds the mode bit in bit 0 (1 = extended, 0 = basic) and the preamble-enable bit in bit 1, both readable. Register 2 holds the write data in bits 15:0. Writing register 1 while idle, with opcode in bits 1:0, PHY address in bits 12:8 and register/device address in bits 20:16, launches a frame when the opcode is defined for the mode.
- R3: In basic mode, opcode 0 sends a write frame (start 01, wire opcode 01, data from register 2) and opcode 1 sends a read frame (start 01, wire opcode 10).
- R4: In extended mode, opcode 0 sends an address frame (start 00, wire opcode 00, data field from register 2), opcode 1 a write frame (wire opcode 01) and opcode 3 a read frame (wire opcode 11).
- R5: With preamble enabled the frame starts with 32 driven ones, giving 64 MDC cycles; with it disabled no preamble is sent and the frame is 32 MDC cycles.
- R6: After any preamble the frame carries start (2), opcode (2), PHY address (5), register/device address (5), turnaround (2) and data (16), MSB first; write and address frames drive turnaround as 1 then 0.
- R7: On a read frame the out-enable is low from the first turnaround bit to the end of the frame, and the 16 data bits are sampled while MDC is high and appear in bits 15:0 of register 3 after completion.
- R8: The valid flag is set at the end of a read only if the second turnaround bit was sampled 0; otherwise it stays 0.
- R9: The write pending flag reads 1 from the launch of a write or address frame until its last bit ends; the read pending flag does the same for a read frame, and the valid flag is cleared when a read launches.
- R10: A command written while a frame is pending is ignored: the frame in flight continues unchanged and no second frame follows.
- R11: Undefined opcodes (2 and 3 in basic mode, 2 in extended mode) launch nothing.
- R12: Each frame bit is one MDC period of 2*CLK_HALF system clocks, MDC low for the first half and high for the second; MDC stays low when idle, so a frame keeps pending high for bits*2*CLK_HALF cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write select |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 2 | Register read select |
| rd_data | output | 32 | Register read value (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_in | input | 1 | Data line sampled value |

## Verification
The hardest conditions to reach are those that depend on the PHY side of the turnaround and on timing inside a running frame: a read whose second turnaround bit is not pulled low, and a command arriving mid-frame. The bench plays the PHY, counting released bit periods on MDC falling edges and presenting a chosen turnaround value and data word, so both a clean read and a failed turnaround are produced on demand. It writes a conflicting command part-way through a preambled write and then confirms that exactly one frame of the expected shape appeared and that the line then stays quiet.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 32;
    localparam int TA_POS     = 14;   // index of first turnaround bit in the frame word
    localparam int DATA_W     = 16;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_CMD  = 2'd1,
        REG_WDAT = 2'd2,
        REG_RDAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       ok;    // opcode defined for this mode
        logic       rd;    // frame receives data
        logic [1:0] wop;   // opcode sent on the wire
    } op_dec_t;

    typedef struct packed {
        logic                  rd;
        logic                  pre;
        logic [FRAME_BITS-1:0] word;
    } frame_t;

    function automatic op_dec_t decode_op(input logic ext, input logic [1:0] op);
        op_dec_t d;
        d = '0;
        if (ext) begin
            case (op)
                2'd0:    d = '{ok: 1'b1, rd: 1'b0, wop: 2'b00};
                2'd1:    d = '{ok: 1'b1, rd: 1'b0, wop: 2'b01};
                2'd3:    d = '{ok: 1'b1, rd: 1'b1, wop: 2'b11};
                default: d = '0;
            endcase
        end else begin
            case (op)
                2'd0:    d = '{ok: 1'b1, rd: 1'b0, wop: 2'b01};
                2'd1:    d = '{ok: 1'b1, rd: 1'b1, wop: 2'b10};
                default: d = '0;
            endcase
        end
        return d;
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_word(
        input logic              ext,
        input op_dec_t           d,
        input logic [4:0]        phy,
        input logic [4:0]        ra,
        input logic [DATA_W-1:0] data
    );
        logic [1:0] st;
        logic [1:0] ta;
        st = ext ? 2'b00 : 2'b01;
        ta = d.rd ? 2'b11 : 2'b10;
        return {st, d.wop, phy, ra, ta, (d.rd ? {DATA_W{1'b0}} : data)};
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic sample_pt,
    output logic bit_end
);
    localparam int PERIOD = 2 * CLK_HALF;
    localparam int CW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == CW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign mdc       = run && (cnt >= CW'(CLK_HALF));
    assign sample_pt = run && (cnt == CW'(CLK_HALF));
    assign bit_end   = run && (cnt == CW'(PERIOD - 1));

endmodule

// File: rtl/mdio_serdes.sv
module mdio_serdes
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  frame_t            frame_in,
    input  logic              sample_pt,
    input  logic              bit_end,
    input  logic              mdio_in,
    output logic              busy,
    output logic              rd_mode,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              done,
    output logic              ta_ok,
    output logic [DATA_W-1:0] rx_data,
    output logic [FRAME_BITS-1:0] word_q
);
    localparam int PW = $clog2(PRE_BITS + FRAME_BITS);

    frame_t        cur;
    logic [PW-1:0] pos;
    logic [PW-1:0] fidx;
    logic          in_pre;
    logic          last;
    logic          released;

    always_comb begin
        in_pre   = cur.pre && (pos < PW'(PRE_BITS));
        fidx     = cur.pre ? (pos - PW'(PRE_BITS)) : pos;
        last     = (pos == (cur.pre ? PW'(PRE_BITS + FRAME_BITS - 1) : PW'(FRAME_BITS - 1)));
        released = cur.rd && !in_pre && (fidx >= PW'(TA_POS));
        mdio_out = busy && (in_pre || cur.word[5'd31 - fidx[4:0]]);
        mdio_oe  = busy && !released;
        done     = busy && bit_end && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cur     <= '0;
            pos     <= '0;
            ta_ok   <= 1'b0;
            rx_data <= '0;
        end else if (launch && !busy) begin
            busy    <= 1'b1;
            cur     <= frame_in;
            pos     <= '0;
            ta_ok   <= 1'b0;
            rx_data <= '0;
        end else if (busy) begin
            if (sample_pt && released) begin
                if (fidx == PW'(TA_POS + 1))
                    ta_ok <= !mdio_in;
                else if (fidx >= PW'(TA_POS + 2))
                    rx_data <= {rx_data[DATA_W-2:0], mdio_in};
            end
            if (bit_end) begin
                if (last)
                    busy <= 1'b0;
                else
                    pos <= pos + 1'b1;
            end
        end
    end

    assign rd_mode = cur.rd;
    assign word_q  = cur.word;

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              busy,
    input  logic              rd_mode,
    input  logic              done,
    input  logic              ta_ok,
    input  logic [DATA_W-1:0] rx_data,
    output logic              launch,
    output frame_t            frame_out,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);
    logic              cfg_ext;
    logic              cfg_pre;
    logic [DATA_W-1:0] wdat;
    logic [DATA_W-1:0] rdat;
    op_dec_t           dec;
    logic              cmd_wr;
    logic              unused_bits;

    assign unused_bits = ^wr_data[31:21];

    always_comb begin
        dec       = decode_op(cfg_ext, wr_data[1:0]);
        cmd_wr    = wr_en && (reg_sel_e'(wr_addr) == REG_CMD);
        launch    = cmd_wr && !busy && dec.ok;
        frame_out = '{rd: dec.rd, pre: cfg_pre,
                      word: build_word(cfg_ext, dec, wr_data[12:8], wr_data[20:16], wdat)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_ext  <= 1'b0;
            cfg_pre  <= 1'b0;
            wdat     <= '0;
            rdat     <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (wr_en && reg_sel_e'(wr_addr) == REG_CFG) begin
                cfg_ext <= wr_data[0];
                cfg_pre <= wr_data[1];
            end
            if (wr_en && reg_sel_e'(wr_addr) == REG_WDAT)
                wdat <= wr_data[DATA_W-1:0];
            if (launch && dec.rd)
                rd_valid <= 1'b0;
            if (done && rd_mode) begin
                rd_valid <= ta_ok;
                rdat     <= rx_data;
            end
        end
    end

    always_comb begin
        case (reg_sel_e'(rd_addr))
            REG_CFG:  rd_data = {30'd0, cfg_pre, cfg_ext};
            REG_CMD:  rd_data = 32'd0;
            REG_WDAT: rd_data = {busy && !rd_mode, 15'd0, wdat};
            REG_RDAT: rd_data = {busy && rd_mode, rd_valid, 14'd0, rdat};
            default:  rd_data = 32'd0;
        endcase
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int CLK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic                  busy;
    logic                  rd_mode;
    logic                  launch;
    logic                  done;
    logic                  ta_ok;
    logic                  rd_valid;
    logic                  sample_pt;
    logic                  bit_end;
    logic [DATA_W-1:0]     rx_data;
    logic [FRAME_BITS-1:0] word_q;
    frame_t                next_frame;

    mdio_clkdiv #(.CLK_HALF(CLK_HALF)) u_div (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .mdc       (mdc),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .rd_mode   (rd_mode),
        .done      (done),
        .ta_ok     (ta_ok),
        .rx_data   (rx_data),
        .launch    (launch),
        .frame_out (next_frame),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    mdio_serdes u_ser (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .frame_in  (next_frame),
        .sample_pt (sample_pt),
        .bit_end   (bit_end),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .rd_mode   (rd_mode),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .ta_ok     (ta_ok),
        .rx_data   (rx_data),
        .word_q    (word_q)
    );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        busy,
    input logic        rd_mode,
    input logic        launch,
    input logic        rd_valid,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [31:0] word_q
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R12

    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy); // R2

    AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == 2'd1) |=> $stable(word_q)); // R10

    AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_mode) |-> !rd_valid); // R9

    AST_READ_STAYS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_mode && !mdio_oe) |=> (!mdio_oe || !busy)); // R7

endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_oe  (mdio_oe),
    .busy     (busy),
    .rd_mode  (rd_mode),
    .launch   (launch),
    .rd_valid (rd_valid),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .word_q   (word_q)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int CLK_PERIOD = 10;
    localparam int DIVH       = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    int checks = 0;
    int failures = 0;

    mdio_master #(.CLK_HALF(DIVH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // PHY model: capture every bit at MDC rise, answer released bits
    logic [63:0] cap_val = '0;
    logic [63:0] cap_oe  = '0;
    int          nbits   = 0;
    logic        last_oe = 1'b1;
    int          rel_cnt = 0;
    int          rel_base = 0;
    logic        resp_ta2 = 1'b0;
    logic [15:0] resp_dat = '0;

    always @(posedge mdc) begin
        cap_val = {cap_val[62:0], mdio_out};
        cap_oe  = {cap_oe[62:0], mdio_oe};
        last_oe = mdio_oe;
        nbits   = nbits + 1;
    end

    always @(negedge mdc) begin
        if (!last_oe) rel_cnt = rel_cnt + 1;
    end

    always_comb begin
        int idx;
        idx = rel_cnt - rel_base;
        if (idx == 0)                 mdio_in = 1'b1;
        else if (idx == 1)            mdio_in = resp_ta2;
        else if (idx >= 2 && idx < 18) mdio_in = resp_dat[17 - idx];
        else                          mdio_in = 1'b1;
    end

    typedef struct packed {
        logic        ext;
        logic        pre;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  ra;
        logic [15:0] wdat;
        logic        ta2;
        logic [15:0] rdat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd0, 5'h03, 5'h11, 16'hA5C3, 1'b0, 16'h0000},
        '{1'b0, 1'b1, 2'd1, 5'h1F, 5'h02, 16'h0000, 1'b0, 16'h1234},
        '{1'b1, 1'b0, 2'd0, 5'h08, 5'h01, 16'h0F0F, 1'b0, 16'h0000},
        '{1'b1, 1'b0, 2'd1, 5'h08, 5'h01, 16'hBEEF, 1'b0, 16'h0000},
        '{1'b1, 1'b1, 2'd3, 5'h15, 5'h07, 16'h0000, 1'b0, 16'hC001},
        '{1'b0, 1'b0, 2'd1, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'hFFFF}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] ra);
        return {11'd0, ra, 3'd0, phy, 6'd0, op};
    endfunction

    function automatic bit is_read(input logic ext, input logic [1:0] op);
        return ext ? (op == 2'd3) : (op == 2'd1);
    endfunction

    function automatic logic [31:0] ref_word(input logic ext, input logic [1:0] op,
                                             input logic [4:0] phy, input logic [4:0] ra,
                                             input logic [15:0] wd);
        logic [1:0] w;
        bit rd;
        rd = is_read(ext, op);
        if (!ext) w = (op == 2'd0) ? 2'b01 : 2'b10;
        else      w = (op == 2'd0) ? 2'b00 : ((op == 2'd1) ? 2'b01 : 2'b11);
        return {(ext ? 2'b00 : 2'b01), w, phy, ra, (rd ? 2'b11 : 2'b10), (rd ? 16'h0 : wd)};
    endfunction

    // compare the last captured frame with the expected one
    task automatic chk_frame(input string tag, input logic pre, input bit rd,
                             input logic [31:0] w);
        logic [63:0] mask, ev, eo;
        logic [31:0] oe32;
        oe32 = rd ? {{14{1'b1}}, 18'd0} : 32'hFFFF_FFFF;
        mask = pre ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        ev   = pre ? {32'hFFFF_FFFF, w} : {32'd0, w};
        eo   = pre ? {32'hFFFF_FFFF, oe32} : {32'd0, oe32};
        chk({tag, " drive-enable pattern"}, cap_oe & mask, eo);
        chk({tag, " driven bits"}, cap_val & cap_oe & mask, ev & eo);
    endtask

    task automatic poll_done(input bit rd, output int cyc, output logic first_valid);
        cyc = 0;
        first_valid = 1'b0;
        rd_addr = rd ? 2'd3 : 2'd2;
        forever begin
            @(negedge clk);
            if (cyc == 0) first_valid = rd_data[30];
            if (rd_data[31]) cyc++;
            else break;
        end
    endtask

    initial begin
        int cyc;
        int base;
        logic fv;
        logic [31:0] w;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);

        // reset state
        rd_addr = 2'd2; #1;
        chk("R1 write pending after reset", rd_data[31], 1'b0);
        rd_addr = 2'd3; #1;
        chk("R1 read pending/valid after reset", rd_data[31:30], 2'b00);
        chk("R1 mdc idle", mdc, 1'b0);
        chk("R1 oe idle", mdio_oe, 1'b0);

        // register readback
        reg_wr(2'd0, 32'h3);
        @(negedge clk); rd_addr = 2'd0; #1;
        chk("R2 config readback", rd_data, 32'h3);
        reg_wr(2'd2, 32'h0000_9A7E);
        @(negedge clk); rd_addr = 2'd2; #1;
        chk("R2 write-data readback", rd_data, 32'h0000_9A7E);

        // vector table
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit rd;
            string otag;
            v = VECS[i];
            rd = is_read(v.ext, v.op);
            otag = v.ext ? "R4" : "R3";
            reg_wr(2'd0, {30'd0, v.pre, v.ext});
            reg_wr(2'd2, {16'd0, v.wdat});
            resp_ta2 = v.ta2;
            resp_dat = v.rdat;
            rel_base = rel_cnt;
            base = nbits;
            reg_wr(2'd1, cmd_word(v.op, v.phy, v.ra));
            poll_done(rd, cyc, fv);
            repeat (2) @(negedge clk);
            chk($sformatf("R5 bit count vec%0d", i), 64'(nbits - base), v.pre ? 64'd64 : 64'd32);
            chk($sformatf("R12 pending cycles vec%0d", i), 64'(cyc),
                64'((v.pre ? 64 : 32) * 2 * DIVH));
            w = ref_word(v.ext, v.op, v.phy, v.ra, v.wdat);
            chk_frame($sformatf("%s R6 vec%0d", otag, i), v.pre, rd, w);
            if (rd) begin
                chk($sformatf("R9 valid cleared at launch vec%0d", i), fv, 1'b0);
                rd_addr = 2'd3; #1;
                chk($sformatf("R8 valid vec%0d", i), rd_data[30], !v.ta2);
                chk($sformatf("R7 read data vec%0d", i), rd_data[15:0], v.rdat);
            end
        end

        // command during a pending frame is ignored
        reg_wr(2'd0, 32'h2);
        reg_wr(2'd2, 32'h0000_5555);
        base = nbits;
        reg_wr(2'd1, cmd_word(2'd0, 5'h01, 5'h02));
        repeat (20) @(negedge clk);
        reg_wr(2'd1, cmd_word(2'd1, 5'h09, 5'h04));
        @(negedge clk); rd_addr = 2'd3; #1;
        chk("R10 no read pending after ignored command", rd_data[31], 1'b0);
        rd_addr = 2'd2; #1;
        chk("R9 write pending mid-frame", rd_data[31], 1'b1);
        poll_done(1'b0, cyc, fv);
        repeat (2) @(negedge clk);
        chk_frame("R10 frame unchanged", 1'b1, 1'b0,
                  ref_word(1'b0, 2'd0, 5'h01, 5'h02, 16'h5555));
        repeat (150) @(negedge clk);
        chk("R10 single frame only", 64'(nbits - base), 64'd64);

        // undefined opcodes
        base = nbits;
        reg_wr(2'd0, 32'h0);
        reg_wr(2'd1, cmd_word(2'd2, 5'h01, 5'h01));
        reg_wr(2'd1, cmd_word(2'd3, 5'h01, 5'h01));
        repeat (40) @(negedge clk);
        rd_addr = 2'd2; #1;
        chk("R11 basic undefined opcode no pending", rd_data[31], 1'b0);
        reg_wr(2'd0, 32'h1);
        reg_wr(2'd1, cmd_word(2'd2, 5'h01, 5'h01));
        repeat (40) @(negedge clk);
        rd_addr = 2'd3; #1;
        chk("R11 extended undefined opcode no pending", rd_data[31], 1'b0);
        chk("R11 no MDC activity", 64'(nbits - base), 64'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R12 act=timeout exp=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule